// File: doc/BRIEF.md
# Parameterized LIFO Stack

This block is a synchronous last-in first-out store. A word on the data input is pushed into an internal register array, and a pop copies the newest stored word into a registered output. That output keeps the word until the next serviced pop. An occupancy counter tracks how many words are held. The same counter drives the full and empty flags and blocks any request that the stack cannot serve.

When push and pop are requested together, the push is performed. The one exception is a full stack: there the push is impossible, so the pop is served instead. An optional clock enable freezes all state. Separate parameters set the active level of the push, pop and enable inputs and of the full and empty outputs, and another parameter selects the rising or falling clock edge. Reset is asynchronous and is the only operation that is not tied to the selected edge.

Top module: `lifo_stack`

## Requirements
- R1: Reset is asynchronous. It sets the occupancy to zero and clears the data output to zero, so after reset the empty flag is active and the full flag is inactive.
- R2: An enabled push with occupancy below DEPTH stores the input word and adds one to the occupancy. A push at occupancy DEPTH is ignored.
- R3: An enabled pop with occupancy above zero puts the most recently pushed word that has not yet been popped on the data output and subtracts one from the occupancy. A pop at occupancy zero changes nothing, and the output keeps its value.
- R4: When push and pop are both active and the stack is not full, only the push is performed, and the data output is unchanged.
- R5: When push and pop are both active and the stack is full, the pop is performed and the push word is dropped.
- R6: The data output changes only on a serviced pop or a reset. Otherwise it holds its value.
- R7: The full flag is active exactly when the occupancy equals DEPTH. Its level is active high when FULL_HI=1 and active low when FULL_HI=0.
- R8: The empty flag is active exactly when the occupancy is zero. Its level is active high when EMPTY_HI=1 and active low when EMPTY_HI=0.
- R9: The push, pop and enable inputs are active high when PUSH_HI, POP_HI and EN_HI are 1, and active low when those parameters are 0.
- R10: While the enable input is inactive, the occupancy, the stored words and the data output all hold their values, whatever push and pop do.
- R11: With RISE_EDGE=1 the state updates on the rising edge of clk. With RISE_EDGE=0 it updates on the falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The active edge is chosen by RISE_EDGE |
| rst | input | 1 | Asynchronous reset, active high |
| enIn | input | 1 | Clock enable. Its level is set by EN_HI |
| pushIn | input | 1 | Push request. Its level is set by PUSH_HI |
| popIn | input | 1 | Pop request. Its level is set by POP_HI |
| dataIn | input | WIDTH | Word to push |
| dataOut | output | WIDTH | Last popped word, held between pops |
| fullOut | output | 1 | Full flag. Its level is set by FULL_HI |
| emptyOut | output | 1 | Empty flag. Its level is set by EMPTY_HI |

## Verification
The assertions check on every active edge that the two flags are never active together. They also check that a blocked push leaves the stack full, that a pop at empty leaves it empty, and that the output holds unless a pop is serviced. Two more checks cover a disabled cycle, which must freeze both the count and the output, and collisions, whose winner must match the occupancy. Only the bench scenarios can show that the words come back in reverse order of entry and that a fully inverted, falling-edge instance behaves the same as the default one. The bench also shows that the falling-edge instance moves half a period before the rising-edge one.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

  // Strobes from control to datapath for one active edge
  typedef struct packed {
    logic push;
    logic pop;
  } lifo_strobe_t;

  // Map between pin level and logical truth for a given polarity
  function automatic logic applyPol(input logic v, input bit activeHigh);
    return activeHigh ? v : ~v;
  endfunction

endpackage

// File: rtl/lifo_ctrl.sv
module lifo_ctrl
  import lifo_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter bit PUSH_HI  = 1'b1,
  parameter bit POP_HI   = 1'b1,
  parameter bit EN_HI    = 1'b1,
  parameter bit FULL_HI  = 1'b1,
  parameter bit EMPTY_HI = 1'b1,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clkEff,
  input  logic             rst,
  input  logic             enIn,
  input  logic             pushIn,
  input  logic             popIn,
  output lifo_strobe_t     strobes,
  output logic [CNT_W-1:0] occ,
  output logic             fullOut,
  output logic             emptyOut
);

  logic enAct, pushAct, popAct;
  logic isFull, isEmpty;

  assign enAct   = applyPol(enIn, EN_HI);
  assign pushAct = applyPol(pushIn, PUSH_HI);
  assign popAct  = applyPol(popIn, POP_HI);

  assign isFull  = (occ == CNT_W'(DEPTH));
  assign isEmpty = (occ == '0);

  // Push wins a collision unless the stack is full (R4, R5)
  always_comb begin
    strobes.push = enAct && pushAct && !isFull;
    strobes.pop  = enAct && popAct && !isEmpty && !strobes.push;
  end

  always_ff @(posedge clkEff or posedge rst) begin
    if (rst) begin
      occ <= '0;
    end else if (strobes.push) begin
      occ <= occ + 1'b1;
    end else if (strobes.pop) begin
      occ <= occ - 1'b1;
    end
  end

  assign fullOut  = applyPol(isFull, FULL_HI);
  assign emptyOut = applyPol(isEmpty, EMPTY_HI);

endmodule

// File: rtl/lifo_data.sv
module lifo_data
  import lifo_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int WIDTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clkEff,
  input  logic             rst,
  input  lifo_strobe_t     strobes,
  input  logic [CNT_W-1:0] occ,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut
);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [WIDTH-1:0] topWord;

  // One register per slot; the slot at index occ takes the pushed word
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic writeHere;
    assign writeHere = strobes.push && (occ == CNT_W'(i));
    always_ff @(posedge clkEff) begin
      if (writeHere) slots[i] <= dataIn;
    end
  end

  // Newest word sits at index occ-1
  always_comb begin
    topWord = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (occ == CNT_W'(i + 1)) topWord = slots[i];
    end
  end

  always_ff @(posedge clkEff or posedge rst) begin
    if (rst) begin
      dataOut <= '0;
    end else if (strobes.pop) begin
      dataOut <= topWord;
    end
  end

endmodule

// File: rtl/lifo_stack.sv
module lifo_stack
  import lifo_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int WIDTH     = 8,
  parameter bit PUSH_HI   = 1'b1,
  parameter bit POP_HI    = 1'b1,
  parameter bit EN_HI     = 1'b1,
  parameter bit FULL_HI   = 1'b1,
  parameter bit EMPTY_HI  = 1'b1,
  parameter bit RISE_EDGE = 1'b1,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enIn,
  input  logic             pushIn,
  input  logic             popIn,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             fullOut,
  output logic             emptyOut
);

  logic             clkEff;
  lifo_strobe_t     strobes;
  logic [CNT_W-1:0] occCount;

  // Edge selection (R11)
  if (RISE_EDGE) begin : g_rise
    assign clkEff = clk;
  end else begin : g_fall
    assign clkEff = ~clk;
  end

  lifo_ctrl #(
    .DEPTH(DEPTH), .PUSH_HI(PUSH_HI), .POP_HI(POP_HI), .EN_HI(EN_HI),
    .FULL_HI(FULL_HI), .EMPTY_HI(EMPTY_HI)
  ) u_ctrl (
    .clkEff(clkEff), .rst(rst), .enIn(enIn), .pushIn(pushIn), .popIn(popIn),
    .strobes(strobes), .occ(occCount), .fullOut(fullOut), .emptyOut(emptyOut)
  );

  lifo_data #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_data (
    .clkEff(clkEff), .rst(rst), .strobes(strobes), .occ(occCount),
    .dataIn(dataIn), .dataOut(dataOut)
  );

endmodule

// File: rtl/lifo_stack_chk.sv
module lifo_stack_chk #(
  parameter int DEPTH     = 8,
  parameter int WIDTH     = 8,
  parameter bit PUSH_HI   = 1'b1,
  parameter bit POP_HI    = 1'b1,
  parameter bit EN_HI     = 1'b1,
  parameter bit FULL_HI   = 1'b1,
  parameter bit EMPTY_HI  = 1'b1,
  parameter bit RISE_EDGE = 1'b1,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             enIn,
  input logic             pushIn,
  input logic             popIn,
  input logic [WIDTH-1:0] dataOut,
  input logic             fullOut,
  input logic             emptyOut,
  input logic [CNT_W-1:0] occ
);

  logic ck, en, psh, pp, full, empty;
  assign ck    = RISE_EDGE ? clk : ~clk;
  assign en    = EN_HI ? enIn : ~enIn;
  assign psh   = PUSH_HI ? pushIn : ~pushIn;
  assign pp    = POP_HI ? popIn : ~popIn;
  assign full  = FULL_HI ? fullOut : ~fullOut;
  assign empty = EMPTY_HI ? emptyOut : ~emptyOut;

  p_reset_state_r1: assert property (@(posedge ck)
    $fell(rst) |-> (empty && !full && dataOut == '0));

  p_flags_excl_r7: assert property (@(posedge ck) disable iff (rst)
    !(full && empty));

  p_full_block_r2: assert property (@(posedge ck) disable iff (rst)
    (en && full && psh && !pp) |=> full);

  p_empty_block_r3: assert property (@(posedge ck) disable iff (rst)
    (en && empty && pp && !psh) |=> (empty && $stable(dataOut)));

  p_collide_push_r4: assert property (@(posedge ck) disable iff (rst)
    (en && psh && pp && !full) |=> (!empty && $stable(dataOut)));

  p_collide_full_r5: assert property (@(posedge ck) disable iff (rst)
    (en && psh && pp && full) |=> !full);

  p_out_hold_r6: assert property (@(posedge ck) disable iff (rst)
    !(en && pp && !empty && (full || !psh)) |=> $stable(dataOut));

  p_enable_hold_r10: assert property (@(posedge ck) disable iff (rst)
    !en |=> ($stable(occ) && $stable(dataOut)));

endmodule

bind lifo_stack lifo_stack_chk #(
  .DEPTH(DEPTH), .WIDTH(WIDTH), .PUSH_HI(PUSH_HI), .POP_HI(POP_HI),
  .EN_HI(EN_HI), .FULL_HI(FULL_HI), .EMPTY_HI(EMPTY_HI), .RISE_EDGE(RISE_EDGE)
) u_chk (
  .clk(clk), .rst(rst), .enIn(enIn), .pushIn(pushIn), .popIn(popIn),
  .dataOut(dataOut), .fullOut(fullOut), .emptyOut(emptyOut), .occ(occCount)
);

// File: tb/sim_lifo_stack.sv
module sim_lifo_stack;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int WIDTH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push = 1'b0, pop = 1'b0, en = 1'b1;
  logic [WIDTH-1:0] din = '0;

  logic [WIDTH-1:0] d0, d1;
  logic f0, e0, f1, e1;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [WIDTH-1:0] mq[$];
  logic [WIDTH-1:0] mOut = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Default polarities, rising edge
  lifo_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
    .clk(clk), .rst(rst), .enIn(en), .pushIn(push), .popIn(pop),
    .dataIn(din), .dataOut(d0), .fullOut(f0), .emptyOut(e0));

  // Every polarity inverted, falling edge (R9, R11)
  lifo_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PUSH_HI(1'b0), .POP_HI(1'b0),
    .EN_HI(1'b0), .FULL_HI(1'b0), .EMPTY_HI(1'b0), .RISE_EDGE(1'b0)) u1 (
    .clk(clk), .rst(rst), .enIn(~en), .pushIn(~push), .popIn(~pop),
    .dataIn(din), .dataOut(d1), .fullOut(f1), .emptyOut(e1));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Compare one instance, given its decoded flags, against expected values
  task automatic cmpUnit(input string tag, input string who, input logic [WIDTH-1:0] d,
                         input logic fAct, input logic eAct, input logic [WIDTH-1:0] ed,
                         input logic ef, input logic ee);
    chk(tag, {who, " dataOut"}, int'(d), int'(ed));
    chk("R7", {who, " full"}, int'(fAct), int'(ef));
    chk("R8", {who, " empty"}, int'(eAct), int'(ee));
  endtask

  task automatic step(input logic p, input logic q, input logic e,
                      input logic [WIDTH-1:0] d, input string tag);
    logic [WIDTH-1:0] oldOut;
    logic oldF, oldE;
    push = p; pop = q; en = e; din = d;
    oldOut = mOut;
    oldF = (mq.size() == DEPTH);
    oldE = (mq.size() == 0);
    if (e) begin
      if (p && mq.size() < DEPTH) mq.push_back(d);
      else if (q && mq.size() > 0) mOut = mq.pop_back();
    end
    @(negedge clk); #1;
    cmpUnit(tag, "u1", d1, ~f1, ~e1, mOut, mq.size() == DEPTH, mq.size() == 0);
    cmpUnit("R11", "u0 before rising edge", d0, f0, e0, oldOut, oldF, oldE);
    @(posedge clk); #1;
    cmpUnit(tag, "u0", d0, f0, e0, mOut, mq.size() == DEPTH, mq.size() == 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    @(posedge clk); @(posedge clk); #1;
    // R1: reset state on both instances
    cmpUnit("R1", "u0", d0, f0, e0, '0, 1'b0, 1'b1);
    cmpUnit("R1", "u1", d1, ~f1, ~e1, '0, 1'b0, 1'b1);
    rst = 1'b0;

    step(0, 1, 1, 8'h00, "R3");   // pop at empty: no change
    step(1, 1, 1, 8'h11, "R4");   // collision at empty: push
    step(1, 0, 1, 8'h22, "R2");
    step(1, 0, 1, 8'h33, "R2");
    step(1, 0, 1, 8'h44, "R2");   // now full
    step(1, 0, 1, 8'h55, "R2");   // blocked push
    step(1, 1, 1, 8'h66, "R5");   // full collision: pop 44
    step(1, 1, 1, 8'h77, "R4");   // partial collision: push 77
    step(0, 0, 1, 8'h99, "R6");   // idle: output holds
    step(1, 1, 0, 8'h88, "R10");  // disabled
    step(0, 1, 0, 8'h00, "R10");
    step(1, 0, 0, 8'hAA, "R10");
    step(0, 1, 1, 8'h00, "R3");   // 77
    step(0, 1, 1, 8'h00, "R3");   // 33
    step(0, 1, 1, 8'h00, "R3");   // 22
    step(0, 1, 1, 8'h00, "R3");   // 11
    step(0, 1, 1, 8'h00, "R3");   // empty pop keeps 11
    step(1, 0, 1, 8'hB0, "R2");   // re-fill from empty
    step(1, 1, 1, 8'hB1, "R4");   // collision with one word held
    step(0, 1, 1, 8'h00, "R3");   // pop newest (B1)

    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[1] | lfsr[4], lfsr[2] | lfsr[3], lfsr[15:8], "R9");
    end
    finishRun();
  end
endmodule